// File: doc/BRIEF.md
# Column-Drain Pixel Hit Readout

This block reads out a matrix of pixels and sends their hits out on a single serial line. Each pixel watches its own discriminator signal. A free-running 8-bit time stamp, shared in Gray code, is latched as is when the signal goes high and again when it goes low. The two stamps sit in separate registers, and their difference is the time over threshold. A pixel holding both stamps raises a hit flag. The flags of all pixels are ORed into one request.

A controller waits for that request and then runs a priority scan. The lowest column wins first, and within that column the lowest row. The controller takes the winning pixel's address and stamps into a 30-bit word and clears the pixel in the same clock. It then shifts the word out at one bit per clock. That clock stands for the 160 Mbit/s serial rate. Any further pending pixels are drained one after another with no gap between words.

The address fields are sized for a matrix of up to 64 columns by 256 rows, which covers a 36 x 142 sensor. The default parameters build a smaller tile. Discriminator inputs are sampled on the block clock. Pixel (c, r) is bit `c*N_ROWS + r` of `disc_i`.

Top module: `pixel_drain_readout`

## Requirements
- R1: While reset is asserted and in the first clock after it is released, `ser_valid_o`, `ser_frame_o`, `ser_data_o` and `hit_req_o` are all 0.
- R2: The shared stamp advances by one every clock and is stored in Gray code. The stamp latched at the first clock a pixel samples its input high is the leading stamp. The stamp latched at the first clock it samples the input low again is the trailing stamp. After both are decoded to binary, trailing minus leading modulo 256 equals the high time in clocks. This holds for widths 1 to 255 and also when the counter wraps.
- R3: A pixel whose input has risen but not yet fallen does not raise `hit_req_o` and causes no output, however long the input stays high.
- R4: `hit_req_o` is high exactly while some pixel holds a complete hit. A word starts only in the clock after the request was seen high. With no request, the serial line stays idle.
- R5: A word is 30 bits, sent MSB first at one bit per clock. Bits 29:24 hold the column, 23:16 the row, 15:8 the leading stamp and 7:0 the trailing stamp. `ser_frame_o` is high on bit 29 only, and `ser_valid_o` is high for exactly the 30 bits.
- R6: When several pixels hold hits, the lowest column is read first. Within one column, the lowest row is read first.
- R7: A pixel holding a hit ignores further discriminator pulses until it is read out. The word it sends carries the first pulse's stamps.
- R8: A pixel is cleared at the clock edge where its word is loaded, so its request drops in that edge. A pulse after readout produces a new word.
- R9: When another hit is pending as a word ends, the next word's frame bit follows the previous word's last bit in the very next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; drives the time stamp and one serial bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| disc_i | input | N_COLS*N_ROWS | Discriminator outputs, pixel (c, r) at bit c*N_ROWS+r |
| hit_req_o | output | 1 | OR of all complete-hit flags |
| ser_data_o | output | 1 | Serial data, MSB first |
| ser_frame_o | output | 1 | High on the first bit of each word |
| ser_valid_o | output | 1 | High while a word's bits are on the line |

## Verification
A pixel stuck in the wrong state shows up at the ports in two ways. It either raises `hit_req_o` while its input is still high, or it sends a word when no pulse was given. Both are seen within a clock or two of the edge that caused them. A mistake in the scan or the packing only shows up one word later, as a wrong address, a wrong stamp difference or the wrong order. So each word is compared in full with the expected queue when its thirtieth bit arrives. The bit count and frame spacing are checked on every clock, which catches a miscounted shift register within the word it corrupts.

// File: rtl/pdr_pkg.sv
package pdr_pkg;

    localparam int COL_W   = 6;
    localparam int ROW_W   = 8;
    localparam int STAMP_W = 8;
    localparam int WORD_W  = COL_W + ROW_W + 2 * STAMP_W;
    localparam int CNT_W   = $clog2(WORD_W);

    typedef logic [STAMP_W-1:0] stamp_t;

    typedef enum logic [1:0] {
        PX_IDLE  = 2'd0,
        PX_ARMED = 2'd1,
        PX_HELD  = 2'd2
    } px_state_e;

    typedef struct packed {
        px_state_e st;
        logic      disc_prev;
        stamp_t    lead;
        stamp_t    trail;
    } px_reg_t;

    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
        stamp_t           lead;
        stamp_t           trail;
    } frame_t;

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  bit_idx;
        logic [WORD_W-1:0] shreg;
    } ser_reg_t;

endpackage

// File: rtl/pdr_stamp_counter.sv
module pdr_stamp_counter
    import pdr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output stamp_t gray_o
);

    stamp_t bin_d, bin_q;

    always_comb begin
        bin_d = bin_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bin_q <= '0;
        else        bin_q <= bin_d;
    end

    // binary to reflected Gray, shared by every pixel
    assign gray_o = bin_q ^ (bin_q >> 1);

endmodule

// File: rtl/pdr_pixel.sv
module pdr_pixel
    import pdr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   disc_i,
    input  stamp_t stamp_i,
    input  logic   clear_i,
    output logic   hit_o,
    output stamp_t lead_o,
    output stamp_t trail_o
);

    px_reg_t px_d, px_q;
    logic    rise, fall;

    always_comb begin
        px_d           = px_q;
        px_d.disc_prev = disc_i;
        rise           = disc_i & ~px_q.disc_prev;
        fall           = ~disc_i & px_q.disc_prev;
        case (px_q.st)
            PX_IDLE: begin
                if (rise) begin
                    px_d.st   = PX_ARMED;
                    px_d.lead = stamp_i;
                end
            end
            PX_ARMED: begin
                if (fall) begin
                    px_d.st    = PX_HELD;
                    px_d.trail = stamp_i;
                end
            end
            PX_HELD: begin
                // edges are ignored here; only readout releases the pixel
                if (clear_i) begin
                    px_d.st    = PX_IDLE;
                    px_d.lead  = '0;
                    px_d.trail = '0;
                end
            end
            default: px_d.st = PX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            px_q.st        <= PX_IDLE;
            px_q.disc_prev <= 1'b0;
            px_q.lead      <= '0;
            px_q.trail     <= '0;
        end else begin
            px_q <= px_d;
        end
    end

    assign hit_o   = (px_q.st == PX_HELD);
    assign lead_o  = px_q.lead;
    assign trail_o = px_q.trail;

endmodule

// File: rtl/pdr_prio_scan.sv
module pdr_prio_scan
    import pdr_pkg::*;
#(
    parameter int N_COLS = 8,
    parameter int N_ROWS = 16,
    localparam int N_PIX = N_COLS * N_ROWS,
    localparam int IDX_W = (N_PIX > 1) ? $clog2(N_PIX) : 1
) (
    input  logic [N_PIX-1:0] hit_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [COL_W-1:0] col_o,
    output logic [ROW_W-1:0] row_o
);

    // scan from the highest index down so that the lowest set index
    // is the last assignment: lowest column, then lowest row
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        col_o   = '0;
        row_o   = '0;
        for (int c = N_COLS - 1; c >= 0; c--) begin
            for (int r = N_ROWS - 1; r >= 0; r--) begin
                if (hit_i[c*N_ROWS + r]) begin
                    found_o = 1'b1;
                    idx_o   = IDX_W'(c * N_ROWS + r);
                    col_o   = COL_W'(c);
                    row_o   = ROW_W'(r);
                end
            end
        end
    end

endmodule

// File: rtl/pdr_ctrl.sv
module pdr_ctrl
    import pdr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_i,
    input  frame_t word_i,
    output logic   grant_o,
    output logic   ser_data_o,
    output logic   ser_frame_o,
    output logic   ser_valid_o
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

    ser_reg_t s_d, s_q;
    logic     grant;

    always_comb begin
        s_d   = s_q;
        grant = 1'b0;
        if (s_q.busy) begin
            s_d.shreg = {s_q.shreg[WORD_W-2:0], 1'b0};
            if (s_q.bit_idx == '0) begin
                s_d.busy = 1'b0;
                grant    = req_i;    // chain the next word without a gap
            end else begin
                s_d.bit_idx = s_q.bit_idx - 1'b1;
            end
        end else begin
            grant = req_i;
        end
        if (grant) begin
            s_d.busy    = 1'b1;
            s_d.bit_idx = LAST_IDX;
            s_d.shreg   = word_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.busy    <= 1'b0;
            s_q.bit_idx <= '0;
            s_q.shreg   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign grant_o     = grant;
    assign ser_valid_o = s_q.busy;
    assign ser_data_o  = s_q.busy & s_q.shreg[WORD_W-1];
    assign ser_frame_o = s_q.busy & (s_q.bit_idx == LAST_IDX);

endmodule

// File: rtl/pixel_drain_readout.sv
module pixel_drain_readout
    import pdr_pkg::*;
#(
    parameter int N_COLS = 8,
    parameter int N_ROWS = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_COLS*N_ROWS-1:0] disc_i,
    output logic                     hit_req_o,
    output logic                     ser_data_o,
    output logic                     ser_frame_o,
    output logic                     ser_valid_o
);

    localparam int N_PIX = N_COLS * N_ROWS;
    localparam int IDX_W = (N_PIX > 1) ? $clog2(N_PIX) : 1;

    stamp_t             ts_gray;
    logic [N_PIX-1:0]   hit_vec;
    logic [N_PIX-1:0]   clr_vec;
    stamp_t             lead_arr  [N_PIX];
    stamp_t             trail_arr [N_PIX];
    logic               win_found;
    logic [IDX_W-1:0]   win_idx;
    logic [COL_W-1:0]   win_col;
    logic [ROW_W-1:0]   win_row;
    logic               grant;
    frame_t             word;

    pdr_stamp_counter u_stamp (
        .clk    (clk),
        .rst_n  (rst_n),
        .gray_o (ts_gray)
    );

    for (genvar c = 0; c < N_COLS; c++) begin : g_col
        for (genvar r = 0; r < N_ROWS; r++) begin : g_row
            localparam int IDX = c * N_ROWS + r;
            assign clr_vec[IDX] = grant & (win_idx == IDX_W'(IDX));
            pdr_pixel u_pix (
                .clk     (clk),
                .rst_n   (rst_n),
                .disc_i  (disc_i[IDX]),
                .stamp_i (ts_gray),
                .clear_i (clr_vec[IDX]),
                .hit_o   (hit_vec[IDX]),
                .lead_o  (lead_arr[IDX]),
                .trail_o (trail_arr[IDX])
            );
        end
    end

    pdr_prio_scan #(
        .N_COLS (N_COLS),
        .N_ROWS (N_ROWS)
    ) u_scan (
        .hit_i   (hit_vec),
        .found_o (win_found),
        .idx_o   (win_idx),
        .col_o   (win_col),
        .row_o   (win_row)
    );

    always_comb begin
        word.col   = win_col;
        word.row   = win_row;
        word.lead  = lead_arr[win_idx];
        word.trail = trail_arr[win_idx];
    end

    pdr_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (win_found),
        .word_i      (word),
        .grant_o     (grant),
        .ser_data_o  (ser_data_o),
        .ser_frame_o (ser_frame_o),
        .ser_valid_o (ser_valid_o)
    );

    assign hit_req_o = win_found;

endmodule

// File: rtl/pdr_checker.sv
module pdr_checker
    import pdr_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic hit_req,
    input logic ser_frame,
    input logic ser_valid
);

    logic [CNT_W:0] run_q;

    // counts valid bits since the latest frame bit
    always_ff @(posedge clk) begin
        if (!rst_n)         run_q <= '0;
        else if (ser_frame) run_q <= 1;
        else if (ser_valid) run_q <= run_q + 1'b1;
    end

    AST_FRAME_IN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        ser_frame |-> ser_valid);                                          // R5
    AST_WORD_OPENS_WITH_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_valid) |-> ser_frame);                                   // R5
    AST_WORD_FULL_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_valid) |-> (run_q == (CNT_W+1)'(WORD_W)));               // R5
    AST_START_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_valid) |-> $past(hit_req));                              // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_req && !ser_valid) |=> !ser_valid);                          // R4
    AST_BACK_TO_BACK_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_frame && $past(ser_valid)) |-> (run_q == (CNT_W+1)'(WORD_W))); // R9

endmodule

bind pixel_drain_readout pdr_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_req   (hit_req_o),
    .ser_frame (ser_frame_o),
    .ser_valid (ser_valid_o)
);

// File: tb/pixel_drain_readout_tb.sv
module pixel_drain_readout_tb;

    localparam int NC = 8;
    localparam int NR = 16;
    localparam int NP = NC * NR;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] disc = '0;
    logic          hit_req, ser_data, ser_frame, ser_valid;

    typedef struct {
        int col;
        int row;
        int width;
    } exp_t;

    exp_t expq[$];
    int   n_checks = 0;
    int   n_fail = 0;
    int   cyc = 0;
    int   last_frame_cyc = -1000;
    int   gap_last = 0;
    bit   finished = 1'b0;

    pixel_drain_readout #(.N_COLS(NC), .N_ROWS(NR)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .disc_i      (disc),
        .hit_req_o   (hit_req),
        .ser_data_o  (ser_data),
        .ser_frame_o (ser_frame),
        .ser_valid_o (ser_valid)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int gray2bin(input logic [7:0] g);
        logic [7:0] b;
        b[7] = g[7];
        for (int i = 6; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return int'(b);
    endfunction

    task automatic expect_hit(input int c, input int r, input int w);
        exp_t e;
        e.col = c; e.row = r; e.width = w;
        expq.push_back(e);
    endtask

    task automatic pulse(input int c, input int r, input int w, input int pre);
        repeat (pre) @(negedge clk);
        disc[c*NR + r] = 1'b1;
        repeat (w) @(negedge clk);
        disc[c*NR + r] = 1'b0;
    endtask

    task automatic drain(input string req);
        int waited = 0;
        while ((expq.size() != 0 || ser_valid) && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        repeat (3) @(negedge clk);
        check(expq.size() == 0, req, "words still expected", expq.size(), 0);
        check(!hit_req && !ser_valid, req, "line idle after drain",
              int'(hit_req) + int'(ser_valid), 0);
    endtask

    // monitor: rebuild words from the line and score them against the queue
    initial begin
        logic [29:0] w = '0;
        int          nb = 0;
        forever begin
            @(negedge clk);
            if (rst_n && ser_valid) begin
                if (ser_frame) begin
                    if (nb != 0) check(1'b0, "R5", "frame inside a word", nb, 0);
                    gap_last       = cyc - last_frame_cyc;
                    last_frame_cyc = cyc;
                    nb             = 0;
                end else if (nb == 0) begin
                    check(1'b0, "R5", "bit without frame", 1, 0);
                end
                w = {w[28:0], ser_data};
                nb++;
                if (nb == 30) begin
                    nb = 0;
                    if (expq.size() == 0) begin
                        check(1'b0, "R4", "unexpected word", int'(w[29:16]), -1);
                    end else begin
                        exp_t e;
                        int   span;
                        e    = expq.pop_front();
                        span = (gray2bin(w[7:0]) - gray2bin(w[15:8]) + 256) % 256;
                        check(int'(w[29:24]) == e.col, "R6", "column", int'(w[29:24]), e.col);
                        check(int'(w[23:16]) == e.row, "R6", "row", int'(w[23:16]), e.row);
                        check(span == e.width, "R2", "time over threshold", span, e.width);
                    end
                end
            end else if (nb != 0) begin
                check(1'b0, "R5", "word cut short", nb, 30);
                nb = 0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            check(1'b0, "R4", "watchdog expired", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int lead_only_bad = 0;

        repeat (4) @(negedge clk);
        // R1: outputs during reset
        check(!ser_valid && !ser_frame && !ser_data && !hit_req, "R1", "outputs in reset",
              int'({ser_valid, ser_frame, ser_data, hit_req}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!ser_valid && !ser_frame && !ser_data && !hit_req, "R1", "outputs after reset",
              int'({ser_valid, ser_frame, ser_data, hit_req}), 0);

        // R2 / R5: single pixel
        expect_hit(2, 5, 10);
        pulse(2, 5, 10, 0);
        drain("R5");

        // R3: leading edge held high, no request
        disc[0*NR + 3] = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (hit_req || ser_valid) lead_only_bad++;
        end
        check(lead_only_bad == 0, "R3", "request while input high", lead_only_bad, 0);
        expect_hit(0, 3, 20);
        disc[0*NR + 3] = 1'b0;
        @(negedge clk);
        check(hit_req == 1'b1, "R4", "request after trailing edge", int'(hit_req), 1);
        @(negedge clk);
        check(ser_valid && ser_frame, "R5", "frame in clock after request",
              int'({ser_valid, ser_frame}), 3);
        check(hit_req == 1'b0, "R8", "request cleared at load", int'(hit_req), 0);
        drain("R3");

        // R6 / R9: four pixels finish together, read in priority order
        expect_hit(0, 15, 13);
        expect_hit(1, 2, 9);
        expect_hit(1, 9, 20);
        expect_hit(3, 1, 4);
        fork
            pulse(3, 1, 4, 16);
            pulse(1, 9, 20, 0);
            pulse(1, 2, 9, 11);
            pulse(0, 15, 13, 7);
        join
        drain("R6");
        check(gap_last == 30, "R9", "frame spacing back to back", gap_last, 30);

        // R7: a waiting pixel ignores a second pulse
        expect_hit(0, 0, 5);
        expect_hit(2, 0, 5);
        fork
            pulse(0, 0, 5, 0);
            pulse(2, 0, 5, 0);
        join
        pulse(2, 0, 3, 2);
        drain("R7");

        // R8: after readout the pixel records a new pulse
        expect_hit(2, 0, 7);
        pulse(2, 0, 7, 0);
        drain("R8");

        // R2: long and short widths, counter wraps on the way
        expect_hit(4, 8, 255);
        pulse(4, 8, 255, 0);
        drain("R2");
        expect_hit(4, 8, 200);
        pulse(4, 8, 200, 0);
        drain("R2");
        expect_hit(4, 8, 1);
        pulse(4, 8, 1, 0);
        drain("R2");
        expect_hit(4, 8, 128);
        pulse(4, 8, 128, 0);
        drain("R2");

        // R6: address corners
        expect_hit(NC-1, NR-1, 33);
        pulse(NC-1, NR-1, 33, 0);
        drain("R6");
        expect_hit(0, 0, 2);
        pulse(0, 0, 2, 0);
        drain("R6");

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule